// File: doc/BRIEF.md
# Multi-queue Tx ring enqueue manager

The block tracks producer and consumer positions for a set of circular transmit rings. Each ring holds fixed-size descriptor slots in host memory. A requester presents a queue number and a frame length. The block works out where the next descriptor slot lives. It records the frame length in that queue's byte-count table through a single memory write port, then acknowledges the request with the slot address.

Every table entry whose slot index falls in the low window is written a second time, into a mirror zone placed just past the 256 primary entries. A consumer can then read a run of entries that crosses the end of the ring without wrapping. Completion pulses, one line per queue, retire descriptors. Per-queue full and empty flags are kept at all times. A ring is treated as full at one below its size, so the write and read positions never meet on a full ring.

Ring base addresses are loaded through a small configuration write port before a queue is used. The table base is a static input.

Top module: `txring_enq_mgr`

## Requirements
- R1: After reset every queue reports empty (`empty_o` all ones), none reports full, and no memory request is raised.
- R2: An accepted enqueue to queue q pulses `enq_done_o` with `enq_slot_addr_o` = ring base of q + idx*128. Here idx is the queue's write position, which then advances by one.
- R3: The primary table write of an enqueue goes to `tbl_base_i` + q*1024 + idx*2. Its data is the 12-bit byte count in bits 11:0, with bits 15:12 zero.
- R4: When idx is 0 to 63, a second write with the same data goes to the primary address + 512 (entry idx+256). It is issued in the cycle after the primary write is accepted. When idx is 64 or more, only the primary write is made.
- R5: While `mem_valid_o` is high and `mem_ready_i` is low, the address and data hold steady. `enq_done_o` is raised only after every table write of that enqueue has been accepted.
- R6: A queue with 255 pending descriptors reports full. An enqueue to it pulses `enq_err_o` instead of `enq_done_o`, raises no memory request and leaves its write position unchanged.
- R7: A pulse on `cmp_i[q]` for a non-empty queue advances its read position by one. The queue reports empty when its pending count is zero.
- R8: A completion pulse on an empty queue is ignored: it changes no position and leaves the queue empty. In the following cycle `cmp_err_o` pulses.
- R9: Queues are independent: traffic on one queue changes no other queue's positions or flags.
- R10: Positions wrap modulo 256. After slot 255 the next enqueue uses slot 0, including its mirror write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Ring base write strobe |
| cfg_q_i | input | 4 | Queue selected for ring base write |
| cfg_base_i | input | 32 | Ring base address value |
| tbl_base_i | input | 32 | Base address of the first byte-count table |
| enq_valid_i | input | 1 | Enqueue request, held until done or error |
| enq_q_i | input | 4 | Target queue of the enqueue |
| enq_bytes_i | input | 12 | Frame byte count |
| enq_done_o | output | 1 | Enqueue accepted and written |
| enq_err_o | output | 1 | Enqueue refused, queue full |
| enq_slot_addr_o | output | 32 | Descriptor slot address, valid with enq_done_o |
| cmp_i | input | 16 | Per-queue completion pulses |
| cmp_err_o | output | 1 | Completion seen on an empty queue |
| full_o | output | 16 | Per-queue full flags |
| empty_o | output | 16 | Per-queue empty flags |
| mem_valid_o | output | 1 | Table write request |
| mem_ready_i | input | 1 | Table write accepted |
| mem_addr_o | output | 32 | Table write byte address |
| mem_data_o | output | 16 | Table write data |

## Verification
The hardest conditions to reach are a ring holding exactly 255 descriptors, and a write position that wraps past slot 255 and lands back in the mirrored window. The bench fills one queue to the limit with an always-ready memory and checks that the next request is refused. It retires one entry and enqueues into slot 255. It then drains the ring and enqueues again so that slot 0 is used a second time, which requires a mirror write. Randomised back-pressure on the memory port and a random mix of enqueues and completions across all queues cover the stall and independence cases.

// File: rtl/txr_pkg.sv
package txr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRIM,
    ST_MIRR,
    ST_ACK,
    ST_ERR
  } enq_st_e;
endpackage

// File: rtl/txr_ptr_bank.sv
module txr_ptr_bank #(
  parameter int NUM_Q = 16,
  parameter int IDX_W = 8,
  localparam int QW = $clog2(NUM_Q)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_w_i,
  input  logic [QW-1:0]    adv_q_i,
  input  logic [NUM_Q-1:0] cmp_i,
  input  logic [QW-1:0]    sel_q_i,
  output logic [IDX_W-1:0] sel_wptr_o,
  output logic             sel_full_o,
  output logic [NUM_Q-1:0] full_o,
  output logic [NUM_Q-1:0] empty_o,
  output logic             cmp_err_o
);
  logic [IDX_W-1:0] wptr [NUM_Q];
  logic [IDX_W-1:0] rptr [NUM_Q];

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    logic [IDX_W-1:0] cnt;
    assign cnt        = wptr[q] - rptr[q];
    assign full_o[q]  = (cnt == {IDX_W{1'b1}});
    assign empty_o[q] = (cnt == '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wptr[q] <= '0;
        rptr[q] <= '0;
      end else begin
        if (adv_w_i && adv_q_i == QW'(q)) wptr[q] <= wptr[q] + 1'b1;
        if (cmp_i[q] && !empty_o[q])     rptr[q] <= rptr[q] + 1'b1;
      end
    end
  end

  assign sel_wptr_o = wptr[sel_q_i];
  assign sel_full_o = full_o[sel_q_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmp_err_o <= 1'b0;
    else         cmp_err_o <= |(cmp_i & empty_o);
  end
endmodule

// File: rtl/txr_addr_gen.sv
module txr_addr_gen #(
  parameter int ADDR_W       = 32,
  parameter int QW           = 4,
  parameter int IDX_W        = 8,
  parameter int SLOT_SHIFT   = 7,
  parameter int STRIDE_SHIFT = 10,
  parameter int ENTRY_SHIFT  = 1
) (
  input  logic [ADDR_W-1:0] tbl_base_i,
  input  logic [ADDR_W-1:0] ring_base_i,
  input  logic [QW-1:0]     q_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              mirror_i,
  output logic [ADDR_W-1:0] tbl_addr_o,
  output logic [ADDR_W-1:0] slot_addr_o
);
  // mirror entry index = idx + ring depth, i.e. the extra top bit
  logic [IDX_W:0] ent;
  assign ent         = {mirror_i, idx_i};
  assign tbl_addr_o  = tbl_base_i + (ADDR_W'(q_i) << STRIDE_SHIFT)
                     + (ADDR_W'(ent) << ENTRY_SHIFT);
  assign slot_addr_o = ring_base_i + (ADDR_W'(idx_i) << SLOT_SHIFT);
endmodule

// File: rtl/txr_enq_fsm.sv
module txr_enq_fsm
  import txr_pkg::*;
#(
  parameter int QW        = 4,
  parameter int IDX_W     = 8,
  parameter int CNT_W     = 12,
  parameter int MIRROR_CNT = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enq_valid_i,
  input  logic [QW-1:0]    enq_q_i,
  input  logic [CNT_W-1:0] enq_bytes_i,
  input  logic [IDX_W-1:0] sel_wptr_i,
  input  logic             sel_full_i,
  input  logic             mem_ready_i,
  output logic [QW-1:0]    lat_q_o,
  output logic [IDX_W-1:0] lat_idx_o,
  output logic [CNT_W-1:0] lat_bytes_o,
  output logic             mirror_o,
  output logic             mem_valid_o,
  output logic             done_o,
  output logic             err_o
);
  enq_st_e st_q, st_d;
  logic    need_mirror;

  assign need_mirror = (int'(lat_idx_o) < MIRROR_CNT);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (enq_valid_i) st_d = sel_full_i ? ST_ERR : ST_PRIM;
      ST_PRIM: if (mem_ready_i) st_d = need_mirror ? ST_MIRR : ST_ACK;
      ST_MIRR: if (mem_ready_i) st_d = ST_ACK;
      ST_ACK:  st_d = ST_IDLE;
      ST_ERR:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      lat_q_o     <= '0;
      lat_idx_o   <= '0;
      lat_bytes_o <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && enq_valid_i) begin
        lat_q_o     <= enq_q_i;
        lat_idx_o   <= sel_wptr_i;
        lat_bytes_o <= enq_bytes_i;
      end
    end
  end

  assign mem_valid_o = (st_q == ST_PRIM) || (st_q == ST_MIRR);
  assign mirror_o    = (st_q == ST_MIRR);
  assign done_o      = (st_q == ST_ACK);
  assign err_o       = (st_q == ST_ERR);
endmodule

// File: rtl/txring_enq_mgr.sv
module txring_enq_mgr #(
  parameter int NUM_Q        = 16,
  parameter int RING_DEPTH   = 256,
  parameter int SLOT_BYTES   = 128,
  parameter int MIRROR_CNT   = 64,
  parameter int TBL_STRIDE   = 1024,
  parameter int ADDR_W       = 32,
  parameter int CNT_W        = 12,
  parameter int ENTRY_W      = 16,
  localparam int QW          = $clog2(NUM_Q),
  localparam int IDX_W       = $clog2(RING_DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [QW-1:0]      cfg_q_i,
  input  logic [ADDR_W-1:0]  cfg_base_i,
  input  logic [ADDR_W-1:0]  tbl_base_i,
  input  logic               enq_valid_i,
  input  logic [QW-1:0]      enq_q_i,
  input  logic [CNT_W-1:0]   enq_bytes_i,
  output logic               enq_done_o,
  output logic               enq_err_o,
  output logic [ADDR_W-1:0]  enq_slot_addr_o,
  input  logic [NUM_Q-1:0]   cmp_i,
  output logic               cmp_err_o,
  output logic [NUM_Q-1:0]   full_o,
  output logic [NUM_Q-1:0]   empty_o,
  output logic               mem_valid_o,
  input  logic               mem_ready_i,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [ENTRY_W-1:0] mem_data_o
);
  localparam int SLOT_SHIFT   = $clog2(SLOT_BYTES);
  localparam int STRIDE_SHIFT = $clog2(TBL_STRIDE);
  localparam int ENTRY_SHIFT  = $clog2(ENTRY_W / 8);

  logic [ADDR_W-1:0] ring_base [NUM_Q];
  logic [IDX_W-1:0]  sel_wptr, lat_idx;
  logic [QW-1:0]     lat_q;
  logic [CNT_W-1:0]  lat_bytes;
  logic              sel_full, mirror, done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_Q; i++) ring_base[i] <= '0;
    end else if (cfg_we_i) begin
      ring_base[cfg_q_i] <= cfg_base_i;
    end
  end

  txr_ptr_bank #(.NUM_Q(NUM_Q), .IDX_W(IDX_W)) ptr_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_w_i    (done),
    .adv_q_i    (lat_q),
    .cmp_i      (cmp_i),
    .sel_q_i    (enq_q_i),
    .sel_wptr_o (sel_wptr),
    .sel_full_o (sel_full),
    .full_o     (full_o),
    .empty_o    (empty_o),
    .cmp_err_o  (cmp_err_o)
  );

  txr_enq_fsm #(.QW(QW), .IDX_W(IDX_W), .CNT_W(CNT_W), .MIRROR_CNT(MIRROR_CNT)) fsm_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enq_valid_i (enq_valid_i),
    .enq_q_i     (enq_q_i),
    .enq_bytes_i (enq_bytes_i),
    .sel_wptr_i  (sel_wptr),
    .sel_full_i  (sel_full),
    .mem_ready_i (mem_ready_i),
    .lat_q_o     (lat_q),
    .lat_idx_o   (lat_idx),
    .lat_bytes_o (lat_bytes),
    .mirror_o    (mirror),
    .mem_valid_o (mem_valid_o),
    .done_o      (done),
    .err_o       (enq_err_o)
  );

  txr_addr_gen #(
    .ADDR_W(ADDR_W), .QW(QW), .IDX_W(IDX_W), .SLOT_SHIFT(SLOT_SHIFT),
    .STRIDE_SHIFT(STRIDE_SHIFT), .ENTRY_SHIFT(ENTRY_SHIFT)
  ) agen_i (
    .tbl_base_i  (tbl_base_i),
    .ring_base_i (ring_base[lat_q]),
    .q_i         (lat_q),
    .idx_i       (lat_idx),
    .mirror_i    (mirror),
    .tbl_addr_o  (mem_addr_o),
    .slot_addr_o (enq_slot_addr_o)
  );

  assign mem_data_o = ENTRY_W'(lat_bytes);
  assign enq_done_o = done;
endmodule

// File: rtl/txring_enq_mgr_chk.sv
module txring_enq_mgr_chk #(
  parameter int NUM_Q   = 16,
  parameter int ADDR_W  = 32,
  parameter int ENTRY_W = 16,
  parameter int CNT_W   = 12
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               mem_valid_o,
  input logic               mem_ready_i,
  input logic [ADDR_W-1:0]  mem_addr_o,
  input logic [ENTRY_W-1:0] mem_data_o,
  input logic               enq_done_o,
  input logic               enq_err_o,
  input logic [NUM_Q-1:0]   cmp_i,
  input logic               cmp_err_o,
  input logic [NUM_Q-1:0]   full_o,
  input logic [NUM_Q-1:0]   empty_o
);
  // R5
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) && $stable(mem_data_o));

  // R3
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> mem_data_o[ENTRY_W-1:CNT_W] == '0);

  // R5
  done_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enq_done_o |-> $past(mem_valid_o && mem_ready_i) && !mem_valid_o);

  // R6
  err_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enq_err_o |-> !mem_valid_o && !enq_done_o);

  // R7
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o & empty_o) == '0);

  // R8
  cmp_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(cmp_i & empty_o) |=> cmp_err_o);

  // R8
  cmp_err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmp_err_o) |-> $past(|cmp_i));
endmodule

bind txring_enq_mgr txring_enq_mgr_chk #(
  .NUM_Q(NUM_Q), .ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W), .CNT_W(CNT_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_valid_o (mem_valid_o),
  .mem_ready_i (mem_ready_i),
  .mem_addr_o  (mem_addr_o),
  .mem_data_o  (mem_data_o),
  .enq_done_o  (enq_done_o),
  .enq_err_o   (enq_err_o),
  .cmp_i       (cmp_i),
  .cmp_err_o   (cmp_err_o),
  .full_o      (full_o),
  .empty_o     (empty_o)
);

// File: tb/txring_enq_mgr_tb_top.sv
`timescale 1ns/1ps
module txring_enq_mgr_tb_top;
  localparam int NQ = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [3:0]  cfg_q_i = '0;
  logic [31:0] cfg_base_i = '0;
  logic [31:0] tbl_base_i = 32'h0040_0000;
  logic        enq_valid_i = 1'b0;
  logic [3:0]  enq_q_i = '0;
  logic [11:0] enq_bytes_i = '0;
  logic        enq_done_o, enq_err_o, cmp_err_o, mem_valid_o;
  logic [31:0] enq_slot_addr_o, mem_addr_o;
  logic [NQ-1:0] cmp_i = '0;
  logic [NQ-1:0] full_o, empty_o;
  logic        mem_ready_i = 1'b0;
  logic [15:0] mem_data_o;

  int checks = 0;
  int fails  = 0;
  int wp [NQ];
  int rp [NQ];
  logic [31:0] rbase [NQ];

  always #5 clk_i = ~clk_i;

  txring_enq_mgr dut_i (.*);

  function automatic int pend(int q);
    return (wp[q] - rp[q]) & 255;
  endfunction

  function automatic logic [31:0] tbl_addr(int q, int idx);
    return tbl_base_i + 32'(q) * 32'd1024 + 32'(idx) * 32'd2;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_status(int q, string req);
    chk(full_o[q] == (pend(q) == 255), req, full_o[q], pend(q) == 255);
    chk(empty_o[q] == (pend(q) == 0), req, empty_o[q], pend(q) == 0);
  endtask

  task automatic do_enq(int q, int bytes, bit rnd);
    bit exp_full = (pend(q) == 255);
    int idx = wp[q];
    int nexp = exp_full ? 0 : ((idx < 64) ? 2 : 1);
    int nwr = 0;
    int cyc = 0;
    bit got_done = 0, got_err = 0;
    @(negedge clk_i);
    enq_valid_i = 1'b1; enq_q_i = 4'(q); enq_bytes_i = 12'(bytes); mem_ready_i = 1'b0;
    while (!(got_done || got_err) && cyc < 60) begin
      @(negedge clk_i);
      cyc++;
      if (enq_done_o) begin
        got_done = 1;
        mem_ready_i = 1'b0;
        // R2
        chk(enq_slot_addr_o == rbase[q] + 32'(idx) * 32'd128, "R2", enq_slot_addr_o,
            rbase[q] + 32'(idx) * 32'd128);
        // R4 R5
        chk(nwr == nexp, "R4", nwr, nexp);
      end else if (enq_err_o) begin
        got_err = 1;
        mem_ready_i = 1'b0;
      end else if (mem_valid_o) begin
        logic [31:0] ea = (nwr == 0) ? tbl_addr(q, idx) : tbl_addr(q, idx) + 32'd512;
        chk(nwr < nexp, (idx < 64) ? "R4" : "R6", nwr, nexp);
        // R3 primary, R4 mirror (idx+256)
        chk(mem_addr_o == ea, (nwr == 0) ? "R3" : "R4", mem_addr_o, ea);
        chk(mem_data_o == {4'b0, 12'(bytes)}, "R3", mem_data_o, {4'b0, 12'(bytes)});
        mem_ready_i = rnd ? 1'($urandom % 2) : 1'b1;
        if (mem_ready_i) nwr++;
      end else begin
        mem_ready_i = 1'b0;
      end
    end
    enq_valid_i = 1'b0;
    mem_ready_i = 1'b0;
    chk(got_done == !exp_full, "R6", got_done, !exp_full);
    chk(got_err == exp_full, "R6", got_err, exp_full);
    if (got_done) wp[q] = (wp[q] + 1) & 255;
    @(negedge clk_i);
  endtask

  task automatic do_cmp(int q);
    bit was_empty = (pend(q) == 0);
    @(negedge clk_i);
    cmp_i = NQ'(1) << q;
    @(negedge clk_i);
    cmp_i = '0;
    chk(cmp_err_o == was_empty, was_empty ? "R8" : "R7", cmp_err_o, was_empty);
    if (!was_empty) rp[q] = (rp[q] + 1) & 255;
    chk_status(q, was_empty ? "R8" : "R7");
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int q = 0; q < NQ; q++) begin wp[q] = 0; rp[q] = 0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    chk(empty_o == '1, "R1", empty_o, 16'hffff);
    chk(full_o == '0, "R1", full_o, 0);
    chk(mem_valid_o == 1'b0, "R1", mem_valid_o, 0);

    for (int q = 0; q < NQ; q++) begin
      rbase[q] = {$urandom} & 32'hffff_8000;
      @(negedge clk_i);
      cfg_we_i = 1'b1; cfg_q_i = 4'(q); cfg_base_i = rbase[q];
      @(negedge clk_i);
      cfg_we_i = 1'b0;
    end

    // R4 mirrored slot 0, then boundary 63/64 on queue 2
    do_enq(0, 12'habc, 1'b0);
    for (int i = 0; i < 66; i++) do_enq(2, i * 37, 1'b1);
    chk_status(2, "R7");

    // R6 fill queue 3 to 255
    for (int i = 0; i < 255; i++) do_enq(3, i, 1'b0);
    chk_status(3, "R6");
    // R9 neighbour untouched
    chk_status(4, "R9");
    do_enq(3, 12'h123, 1'b0);
    chk_status(3, "R6");
    do_cmp(3);
    // R10 slot 255 then wrap
    do_enq(3, 12'hfff, 1'b1);
    chk_status(3, "R6");
    for (int i = 0; i < 255; i++) do_cmp(3);
    chk_status(3, "R10");
    do_cmp(3);
    do_enq(3, 12'h055, 1'b1);
    chk(wp[3] == 1, "R10", wp[3], 1);

    // R8 empty completion on untouched queue
    do_cmp(7);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int q = $urandom % NQ;
      if ($urandom % 10 < 7) do_enq(q, $urandom % 4096, 1'b1);
      else do_cmp(q);
    end
    // R9 all flags consistent with per-queue model
    for (int q = 0; q < NQ; q++) chk_status(q, "R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule